// File: doc/BRIEF.md
# CEC Receive Address Filter and Acknowledge Responder

This block sits behind the bit-level receiver of a CEC follower. Each time the bit layer finishes a byte, it hands over the byte, a flag marking the first byte after a start bit (the header), and the end-of-message bit. The block decodes the header's destination nibble against a mask of enabled logical addresses. It then decides whether the message is acknowledged and received, received silently (listen mode), or ignored. For every byte it accepts, it sets the level that the bit layer must drive in the following acknowledge slot.

Accepted bytes go into a receive data register. Four sticky status flags record the outcome: byte received, end of reception, overrun and missing acknowledge. Software clears each flag by writing 1 to its bit. At the end of each acknowledge slot the bit layer reports the sampled line level. The block uses that level to detect a missing acknowledge on messages that it does not acknowledge itself.

Top module: `cec_rx_filter`

## Requirements
- R1: After reset every output is 0. While `enable` is low, all flags, `rx_data` and `ack_low` are forced to 0, incoming bytes are ignored, and the block waits for a new header.
- R2: The destination is header bits [3:0]. Mask bit i (i = 0..14) enables address i. Address 15 is broadcast and needs no mask bit.
- R3: A header whose destination is enabled is stored and acknowledged. `ack_low` is 1 from the cycle after the byte until the cycle after `ack_done`. Later bytes of that message are acknowledged in the same way.
- R4: When listen mode is off, a header addressed elsewhere changes no flag, no data and no acknowledge, and the rest of that message is ignored as well.
- R5: When listen mode is on, a header addressed elsewhere is received with `ack_low` at 0. If the acknowledge slot is then sampled high, the missing-acknowledge flag (bit 3) is set and the rest of the message is ignored. A low sample counts as an acknowledge.
- R6: A broadcast is always received and is accepted by leaving `ack_low` at 0. A low sample in its acknowledge slot sets the missing-acknowledge flag and aborts reception.
- R7: For a byte that carries end-of-message, the end-of-reception flag (bit 1) is set in the same cycle as the byte-received flag (bit 0).
- R8: A byte that arrives while the byte-received flag is set raises overrun (bit 2), leaves `rx_data` unchanged, and stops reception. For a directed or listened message no acknowledge is driven. For a broadcast `ack_low` is 1 (negative acknowledge). No missing-acknowledge check follows an overrun.
- R9: `flag_clr` bit n clears flag n. A hardware set wins over a clear in the same cycle. Overrun is judged from the byte-received flag as it stood before that cycle's clear.
- R10: A byte marked as header always restarts address decoding, whatever state the previous message left. A non-header byte outside an accepted message is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears reception state |
| own_mask | input | 15 | One enable bit per logical address 0..14 |
| listen | input | 1 | Receive messages addressed elsewhere, without acknowledging |
| rx_valid | input | 1 | One-cycle pulse: a byte is complete |
| rx_byte | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the header of a new message |
| rx_eom | input | 1 | Byte carries end-of-message |
| ack_done | input | 1 | One-cycle pulse at the end of an acknowledge slot |
| ack_line | input | 1 | Line level sampled in that slot |
| flag_clr | input | 4 | Write-1-to-clear: bit0 byte, bit1 end, bit2 overrun, bit3 missing ack |
| rx_data | output | 8 | Receive data register |
| flag_byte | output | 1 | Byte received |
| flag_end | output | 1 | End of reception |
| flag_ovr | output | 1 | Overrun |
| flag_ackmiss | output | 1 | Missing acknowledge |
| ack_low | output | 1 | Drive the coming acknowledge slot low |

## Verification
The bench goes after the places where acknowledge polarity flips.

- A broadcast that drove its acceptance, or that stayed silent on overrun, would show up as a wrong `ack_low`.
- A listen-mode message that treated a high slot as acceptance would miss its missing-acknowledge flag.
- A design that stored a byte on overrun would overwrite `rx_data`.
- A design that let a clear beat a same-cycle set would lose the overrun flag.
- A design that kept its message state across a disable, or that ignored a fresh header after an abort, would receive or drop the following bytes wrongly.

Mask edges (addresses 0 and 14) and header-only messages are covered too.

// File: rtl/cec_rxf_pkg.sv
`timescale 1ns/1ps
package cec_rxf_pkg;
  localparam int DST_W = 4;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_LISTEN = 2'd1,
    MODE_BCAST  = 2'd2
  } rx_mode_e;

  // Level the block must drive in the acknowledge slot for a byte
  // taken in mode m; ovr tells whether that byte overran the buffer.
  function automatic logic slot_drive_low(rx_mode_e m, logic ovr);
    case (m)
      MODE_DIRECT: slot_drive_low = ~ovr;
      MODE_BCAST:  slot_drive_low = ovr;
      default:     slot_drive_low = 1'b0;
    endcase
  endfunction

  // True when the sampled slot level means "accepted" for mode m.
  function automatic logic slot_level_ok(rx_mode_e m, logic line);
    case (m)
      MODE_BCAST:  slot_level_ok = line;
      MODE_LISTEN: slot_level_ok = ~line;
      default:     slot_level_ok = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/cec_addr_match.sv
`timescale 1ns/1ps
module cec_addr_match
  import cec_rxf_pkg::*;
#(
  parameter int NUM_ADDR = 15
) (
  input  logic [DST_W-1:0]    dst,
  input  logic [NUM_ADDR-1:0] mask,
  input  logic                listen,
  output logic                is_bcast,
  output logic                is_hit,
  output logic                accept,
  output rx_mode_e            mode
);
  localparam logic [DST_W-1:0] BCAST_ADDR = DST_W'((1 << DST_W) - 1);

  logic [NUM_ADDR-1:0] hit_vec;

  for (genvar i = 0; i < NUM_ADDR; i++) begin : g_slot
    assign hit_vec[i] = mask[i] && (dst == DST_W'(i));
  end

  always_comb begin
    is_bcast = (dst == BCAST_ADDR);
    is_hit   = |hit_vec;
    accept   = is_bcast || is_hit || listen;
    if (is_bcast)    mode = MODE_BCAST;
    else if (is_hit) mode = MODE_DIRECT;
    else             mode = MODE_LISTEN;
  end
endmodule

// File: rtl/cec_rx_ctrl.sv
`timescale 1ns/1ps
module cec_rx_ctrl
  import cec_rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     rx_valid,
  input  logic     rx_sof,
  input  logic     rx_eom,
  input  logic     ack_done,
  input  logic     ack_line,
  input  logic     byte_pending,
  input  logic     hdr_accept,
  input  rx_mode_e hdr_mode,
  output logic     store_ev,
  output logic     end_ev,
  output logic     ovr_ev,
  output logic     miss_ev,
  output logic     ack_low
);
  logic     active_q;
  logic     chk_q;
  rx_mode_e mode_q;

  logic     hdr_ev, body_ev, take;
  rx_mode_e cur_mode;

  always_comb begin
    hdr_ev   = enable && rx_valid && rx_sof;
    body_ev  = enable && rx_valid && !rx_sof && active_q;
    take     = hdr_ev ? hdr_accept : body_ev;
    cur_mode = hdr_ev ? hdr_mode : mode_q;
    ovr_ev   = take && byte_pending;
    store_ev = take && !byte_pending;
    end_ev   = store_ev && rx_eom;
    miss_ev  = enable && ack_done && !rx_valid && chk_q &&
               !slot_level_ok(mode_q, ack_line);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      chk_q    <= 1'b0;
      mode_q   <= MODE_DIRECT;
      ack_low  <= 1'b0;
    end else if (!enable) begin
      active_q <= 1'b0;
      chk_q    <= 1'b0;
      mode_q   <= MODE_DIRECT;
      ack_low  <= 1'b0;
    end else if (take) begin
      active_q <= store_ev && !rx_eom;
      mode_q   <= cur_mode;
      chk_q    <= store_ev && (cur_mode != MODE_DIRECT);
      ack_low  <= slot_drive_low(cur_mode, ovr_ev);
    end else if (hdr_ev) begin
      active_q <= 1'b0;
      chk_q    <= 1'b0;
      ack_low  <= 1'b0;
    end else if (ack_done && !rx_valid) begin
      ack_low <= 1'b0;
      chk_q   <= 1'b0;
      if (miss_ev) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cec_rx_flags.sv
`timescale 1ns/1ps
module cec_rx_flags #(
  parameter int BYTE_W  = 8,
  parameter int N_FLAGS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               store_ev,
  input  logic [BYTE_W-1:0]  din,
  input  logic [N_FLAGS-1:0] set_vec,
  input  logic [N_FLAGS-1:0] clr_vec,
  output logic [BYTE_W-1:0]  data_q,
  output logic [N_FLAGS-1:0] flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (!enable)   data_q <= '0;
    else if (store_ev)  data_q <= din;
  end

  for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               flag_q[f] <= 1'b0;
      else if (!enable)         flag_q[f] <= 1'b0;
      else if (set_vec[f])      flag_q[f] <= 1'b1;
      else if (clr_vec[f])      flag_q[f] <= 1'b0;
    end
  end
endmodule

// File: rtl/cec_rx_filter.sv
`timescale 1ns/1ps
module cec_rx_filter
  import cec_rxf_pkg::*;
#(
  parameter int NUM_ADDR = 15,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [NUM_ADDR-1:0] own_mask,
  input  logic                listen,
  input  logic                rx_valid,
  input  logic [BYTE_W-1:0]   rx_byte,
  input  logic                rx_sof,
  input  logic                rx_eom,
  input  logic                ack_done,
  input  logic                ack_line,
  input  logic [3:0]          flag_clr,
  output logic [BYTE_W-1:0]   rx_data,
  output logic                flag_byte,
  output logic                flag_end,
  output logic                flag_ovr,
  output logic                flag_ackmiss,
  output logic                ack_low
);
  localparam int N_FLAGS = 4;

  // decoded header and per-cycle events, named for the checker
  logic     hdr_bcast, hdr_hit, hdr_accept;
  rx_mode_e hdr_mode;
  logic     store_ev, end_ev, ovr_ev, miss_ev;
  logic [N_FLAGS-1:0] flag_vec;

  cec_addr_match #(.NUM_ADDR(NUM_ADDR)) u_match (
    .dst      (rx_byte[DST_W-1:0]),
    .mask     (own_mask),
    .listen   (listen),
    .is_bcast (hdr_bcast),
    .is_hit   (hdr_hit),
    .accept   (hdr_accept),
    .mode     (hdr_mode)
  );

  cec_rx_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .rx_valid     (rx_valid),
    .rx_sof       (rx_sof),
    .rx_eom       (rx_eom),
    .ack_done     (ack_done),
    .ack_line     (ack_line),
    .byte_pending (flag_byte),
    .hdr_accept   (hdr_accept),
    .hdr_mode     (hdr_mode),
    .store_ev     (store_ev),
    .end_ev       (end_ev),
    .ovr_ev       (ovr_ev),
    .miss_ev      (miss_ev),
    .ack_low      (ack_low)
  );

  cec_rx_flags #(.BYTE_W(BYTE_W), .N_FLAGS(N_FLAGS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .store_ev (store_ev),
    .din      (rx_byte),
    .set_vec  ({miss_ev, ovr_ev, end_ev, store_ev}),
    .clr_vec  (flag_clr),
    .data_q   (rx_data),
    .flag_q   (flag_vec)
  );

  assign flag_byte    = flag_vec[0];
  assign flag_end     = flag_vec[1];
  assign flag_ovr     = flag_vec[2];
  assign flag_ackmiss = flag_vec[3];
endmodule

// File: rtl/cec_rx_filter_chk.sv
`timescale 1ns/1ps
module cec_rx_filter_chk
  import cec_rxf_pkg::*;
#(
  parameter int NUM_ADDR = 15,
  parameter int BYTE_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic [NUM_ADDR-1:0] own_mask,
  input logic                listen,
  input logic                rx_valid,
  input logic [BYTE_W-1:0]   rx_byte,
  input logic                rx_sof,
  input logic [3:0]          flag_clr,
  input logic [BYTE_W-1:0]   rx_data,
  input logic                flag_byte,
  input logic                flag_end,
  input logic                flag_ovr,
  input logic                flag_ackmiss,
  input logic                ack_low,
  input logic                store_ev,
  input logic                ovr_ev
);
  localparam int MW = 1 << DST_W;
  logic [MW-1:0]    mask_ext;
  logic [DST_W-1:0] dst;
  logic             is_bc, enabled_dst, hdr_in;

  assign mask_ext    = MW'(own_mask);
  assign dst         = rx_byte[DST_W-1:0];
  assign is_bc       = (dst == DST_W'(MW - 1));
  assign enabled_dst = !is_bc && mask_ext[dst];
  assign hdr_in      = enable && rx_valid && rx_sof;

  // R1
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!flag_byte && !flag_end && !flag_ovr && !flag_ackmiss &&
                 !ack_low && rx_data == '0));

  // R3
  directed_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_in && enabled_dst && !flag_byte) |=> (ack_low && rx_data == $past(rx_byte)));

  // R4
  ignore_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_in && !listen && !is_bc && !enabled_dst && flag_clr == 4'b0)
    |=> (!ack_low && $stable(rx_data) &&
         $stable({flag_byte, flag_end, flag_ovr, flag_ackmiss})));

  // R6
  bcast_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_in && is_bc && !flag_byte) |=> (!ack_low && flag_byte));

  // R7
  end_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_end) |-> $rose(flag_byte));

  // R8
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovr) |-> $stable(rx_data));

  // R8
  bcast_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_in && is_bc && flag_byte) |=> (ack_low && flag_ovr));

  // R8
  store_xor_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_ev, ovr_ev}));
endmodule

bind cec_rx_filter cec_rx_filter_chk #(.NUM_ADDR(NUM_ADDR), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .own_mask     (own_mask),
  .listen       (listen),
  .rx_valid     (rx_valid),
  .rx_byte      (rx_byte),
  .rx_sof       (rx_sof),
  .flag_clr     (flag_clr),
  .rx_data      (rx_data),
  .flag_byte    (flag_byte),
  .flag_end     (flag_end),
  .flag_ovr     (flag_ovr),
  .flag_ackmiss (flag_ackmiss),
  .ack_low      (ack_low),
  .store_ev     (store_ev),
  .ovr_ev       (ovr_ev)
);

// File: tb/cec_rx_filter_tb.sv
`timescale 1ns/1ps
module cec_rx_filter_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, enable = 1'b1, listen = 1'b0;
  logic [14:0] own_mask = 15'h0021;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eom = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        ack_done = 1'b0, ack_line = 1'b1;
  logic [3:0]  flag_clr = 4'h0;
  logic [7:0]  rx_data;
  logic        flag_byte, flag_end, flag_ovr, flag_ackmiss, ack_low;

  int n_tests = 0, n_fail = 0;

  cec_rx_filter u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .own_mask(own_mask),
    .listen(listen), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_sof(rx_sof),
    .rx_eom(rx_eom), .ack_done(ack_done), .ack_line(ack_line),
    .flag_clr(flag_clr), .rx_data(rx_data), .flag_byte(flag_byte),
    .flag_end(flag_end), .flag_ovr(flag_ovr), .flag_ackmiss(flag_ackmiss),
    .ack_low(ack_low)
  );

  // ---------------- behavioural reference ----------------
  // mode: 0 addressed to us, 1 listened, 2 broadcast
  bit       m_busy, m_check, m_ack;
  int       m_mode;
  bit [7:0] m_data;
  bit [3:0] m_flags;   // {ackmiss, ovr, end, byte}

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !enable) begin
      m_busy <= 0; m_check <= 0; m_ack <= 0; m_mode <= 0;
      m_data <= 0; m_flags <= 0;
    end else begin
      automatic bit [3:0] setf = 0;
      automatic bit taken = 0;
      automatic int md = m_mode;
      if (rx_valid && rx_sof) begin
        automatic int d = rx_byte[3:0];
        if (d == 15) begin md = 2; taken = 1; end
        else if (own_mask[d]) begin md = 0; taken = 1; end
        else if (listen) begin md = 1; taken = 1; end
        if (!taken) begin m_busy <= 0; m_check <= 0; m_ack <= 0; end
      end else if (rx_valid && m_busy) begin
        taken = 1;
      end else if (ack_done && !rx_valid) begin
        m_ack <= 0; m_check <= 0;
        if (m_check && ((m_mode == 2 && !ack_line) || (m_mode == 1 && ack_line))) begin
          setf[3] = 1; m_busy <= 0;
        end
      end
      if (taken) begin
        m_mode <= md;
        if (m_flags[0]) begin
          setf[2] = 1; m_busy <= 0; m_check <= 0;
          m_ack <= (md == 2);
        end else begin
          setf[0] = 1; setf[1] = rx_eom; m_data <= rx_byte;
          m_busy <= !rx_eom; m_check <= (md != 0);
          m_ack <= (md == 0);
        end
      end
      m_flags <= (m_flags & ~flag_clr) | setf;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (ack_low !== m_ack) begin
        n_fail++; $display("FAIL R3 model ack_low act=%0d exp=%0d t=%0t", ack_low, m_ack, $time);
      end
      if (rx_data !== m_data) begin
        n_fail++; $display("FAIL R2 model rx_data act=%02h exp=%02h t=%0t", rx_data, m_data, $time);
      end
      if ({flag_ackmiss, flag_ovr, flag_end, flag_byte} !== m_flags) begin
        n_fail++; $display("FAIL R7 model flags act=%b exp=%b t=%0t",
          {flag_ackmiss, flag_ovr, flag_end, flag_byte}, m_flags, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic sof, input logic eom);
    @(negedge clk); rx_valid = 1; rx_byte = b; rx_sof = sof; rx_eom = eom;
    @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eom = 0;
  endtask

  task automatic slot(input logic line);
    @(negedge clk); ack_done = 1; ack_line = line;
    @(negedge clk); ack_done = 0; ack_line = 1;
  endtask

  task automatic clr(input logic [3:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {rx_data, flag_byte, flag_end, flag_ovr, flag_ackmiss, ack_low}, 0);

    // R3 / R2: directed to address 5 with mask 0x0021
    send(8'h45, 1, 0);
    chk("R3 ack driven", ack_low, 1);
    chk("R2 data stored", rx_data, 8'h45);
    slot(1);
    chk("R3 ack released", ack_low, 0);
    clr(4'b0001);
    send(8'h36, 0, 1);
    chk("R7 end with byte", {flag_end, flag_byte}, 2'b11);
    slot(0); clr(4'hF);

    // R4: address 3 not enabled, listen off
    send(8'h43, 1, 0);
    chk("R4 header ignored", {flag_byte, ack_low, rx_data}, {2'b00, 8'h36});
    send(8'h11, 0, 1);
    chk("R4 body ignored", {flag_byte, rx_data}, {1'b0, 8'h36});

    // R2: address 0 enabled
    send(8'h40, 1, 1);
    chk("R2 address 0 acked", ack_low, 1);
    slot(0); clr(4'hF);

    // R5: listen mode
    listen = 1;
    send(8'h43, 1, 0);
    chk("R5 listen no ack", {ack_low, flag_byte}, 2'b01);
    slot(1);
    chk("R5 missing ack", flag_ackmiss, 1);
    clr(4'hF);
    send(8'h22, 0, 0);
    chk("R5 aborted body ignored", flag_byte, 0);
    send(8'h43, 1, 0);
    slot(0);
    chk("R5 acked by other", flag_ackmiss, 0);
    clr(4'b0001);
    send(8'h99, 0, 1);
    chk("R5 listened body", {rx_data, flag_end}, {8'h99, 1'b1});
    slot(0); clr(4'hF); listen = 0;

    // R6: broadcast
    send(8'h4F, 1, 0);
    chk("R6 bcast silent accept", {ack_low, flag_byte}, 2'b01);
    slot(1);
    chk("R6 no miss on high", flag_ackmiss, 0);
    clr(4'b0001);
    send(8'h55, 0, 0);
    slot(0);
    chk("R6 nack sets miss", flag_ackmiss, 1);
    clr(4'hF);
    send(8'h66, 0, 1);
    chk("R6 aborted body ignored", flag_byte, 0);

    // R8: directed overrun
    send(8'h45, 1, 0);
    slot(1);
    send(8'h77, 0, 0);
    chk("R8 directed overrun", {flag_ovr, ack_low, rx_data}, {2'b10, 8'h45});
    slot(1);
    send(8'h78, 0, 1);
    chk("R8 stopped after ovr", rx_data, 8'h45);
    clr(4'hF);

    // R8: broadcast overrun drives negative ack
    send(8'h4F, 1, 0);
    slot(1);
    send(8'h77, 0, 0);
    chk("R8 bcast ovr nack", {flag_ovr, ack_low}, 2'b11);
    slot(0);
    chk("R8 no miss after ovr", flag_ackmiss, 0);

    // R9: clear and set in one cycle
    @(negedge clk); rx_valid = 1; rx_byte = 8'h45; rx_sof = 1; flag_clr = 4'hF;
    @(negedge clk); rx_valid = 0; rx_sof = 0; flag_clr = 0;
    chk("R9 set beats clear", {flag_ovr, flag_byte, rx_data}, {2'b10, 8'h4F});
    slot(1); clr(4'hF);

    // R10: a new header restarts decoding
    send(8'h43, 1, 0);
    send(8'h45, 1, 1);
    chk("R10 new header decoded", {flag_byte, rx_data}, {1'b1, 8'h45});
    slot(0);

    // R1: disable clears and blocks reception
    @(negedge clk); enable = 0;
    @(negedge clk);
    chk("R1 disable clears", {rx_data, flag_byte, flag_end, flag_ovr, flag_ackmiss, ack_low}, 0);
    send(8'h45, 1, 1);
    chk("R1 disabled ignores", flag_byte, 0);
    enable = 1;

    // R2: address 14 edge
    own_mask = 15'h4000;
    send(8'h4E, 1, 1);
    chk("R2 address 14 acked", ack_low, 1);
    slot(0); clr(4'hF);
    send(8'h40, 1, 1);
    chk("R2 address 0 off", {ack_low, flag_byte}, 2'b00);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule